// File: doc/BRIEF.md
# Banked Multi-Processor Interrupt Distributor

This block collects interrupt lines from the rest of a small multi-processor chip and forwards them to the processor interfaces. Software configures it through a single-cycle word-addressed register port. Each line has an enable, a pending state, a trigger mode, an 8-bit priority value and a per-processor routing mask. The block latches edge inputs into pending state and follows level inputs. Every cycle, for each processor, it registers the most urgent line that is enabled, pending and routed to that processor.

The lowest 32 line numbers are private to each processor. The caller names itself on `reg_cpu`, and that selects which copy of the enable and pending bits an access reaches. Lines 0-15 have no input wire and are raised only by software. A processor can raise one of them in any set of processors with a single write. Lines 16-31 come from a per-processor input bus. Lines 32 and above are shared and are steered by their target masks.

Top module: `intd_distributor`

## Requirements
- R1: After reset the control bit, all enables, all pending bits, all priorities (0x00) and all shared targets (0x00) are clear, every shared line is level-triggered, and every `irq_valid` bit is 0.
- R2: Word 0x000 bit 0 is the forwarding switch. While it is 0 every `irq_valid` bit is 0. A write of 0 clears all of them no later than the second clock edge after the write.
- R3: Enables are reached at words 0x040+w (set view) and 0x050+w (clear view), with line 32w+b at bit b. A 1 written to the set view enables the line, a 1 written to the clear view disables it, and 0 bits change nothing. Both views read back the current enables.
- R4: Pending bits are reached the same way at 0x060+w (set view) and 0x070+w (clear view). A read returns the effective pending state.
- R5: Trigger configuration sits at 0x300+w with two bits per line: line 16w+k uses bits 2k+1:2k, and bit 2k+1 = 1 selects rising edge while 0 selects level-high. Only the upper bit is stored, so the lower bit reads 0. Word 0 (lines 0-15) always reads 0xAAAAAAAA, and writes to it are ignored.
- R6: An edge line becomes pending on a 0-to-1 input transition. It stays pending after the input falls, until it is cleared. A level line is pending exactly while its input is high, and a clear has no lasting effect while the input stays high.
- R7: Priority sits at 0x100+w and target at 0x200+w. Byte k (bits 8k+7:8k) belongs to line 4w+k, and target bit c selects processor c. For lines 0-31 the target byte reads as the caller's own processor bit, and writes to it are ignored.
- R8: For lines 0-31 the enable and pending bits exist once per processor, and `reg_cpu` selects the copy. Line 16+i of processor c is driven by `ppi_in[16c+i]`. Line 32+j is driven by `spi_in[j]`.
- R9: A write to word 0x3C0 sets line `wdata[3:0]` pending in the private copy of each processor c whose bit `wdata[16+c]` is 1. Other processors are not affected.
- R10: For each processor, the output presents the enabled, pending and routed line with the lowest priority value. On a tie the lower line number wins. Outputs are registered and follow the state one clock later.
- R11: Word 0x001 reads NUM_LINES/32-1 in bits 4:0 (1 for 64 lines). Word 0x000 reads back the forwarding bit. Word 0x3C0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe; the access completes at this clock edge |
| reg_cpu | input | 3 | Index of the processor making the access, selects the private copy |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ppi_in | input | NUM_CPUS*16 | Private inputs for lines 16-31, 16 per processor |
| spi_in | input | NUM_LINES-32 | Shared inputs for lines 32 and up |
| irq_valid | output | NUM_CPUS | A line is being presented to processor c |
| irq_id | output | NUM_CPUS*clog2(NUM_LINES) | Line number presented to each processor |
| irq_prio | output | NUM_CPUS*8 | Priority value of the presented line |

## Verification
On every cycle the checker enforces the following: forwarding goes dark after a disable write, an output is never valid without the switch being on, the constant words hold their read values (type word, fixed configuration word, software-interrupt word), and enable writes land exactly on the set or cleared bits while enables never move without a write. Arbitration order is covered only by the bench scenarios, which exercise priority ties, reprioritisation and private-versus-shared routing. The same holds for the difference between latched edge inputs and followed level inputs, and for software interrupts reaching only the addressed processors' copies.

// File: rtl/intd_pkg.sv
package intd_pkg;
   localparam int REG_AW     = 10;
   localparam int CPU_SEL_W  = 3;
   localparam int MAX_CPUS   = 8;
   localparam int BANK_LINES = 32;
   localparam int SGI_LINES  = 16;
   localparam int PPI_LINES  = BANK_LINES - SGI_LINES;
   localparam int PRIO_W     = 8;

   localparam logic [REG_AW-1:0] A_CTRL   = 10'h000;
   localparam logic [REG_AW-1:0] A_TYPE   = 10'h001;
   localparam logic [REG_AW-1:0] A_ENSET  = 10'h040;
   localparam logic [REG_AW-1:0] A_ENCLR  = 10'h050;
   localparam logic [REG_AW-1:0] A_PNDSET = 10'h060;
   localparam logic [REG_AW-1:0] A_PNDCLR = 10'h070;
   localparam logic [REG_AW-1:0] A_PRIO   = 10'h100;
   localparam logic [REG_AW-1:0] A_TGT    = 10'h200;
   localparam logic [REG_AW-1:0] A_CFG    = 10'h300;
   localparam logic [REG_AW-1:0] A_SWI    = 10'h3C0;
endpackage

// File: rtl/intd_pend_cell.sv
module intd_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   input  logic edge_mode,
   input  logic sw_set,
   input  logic sw_clr,
   output logic pend_o
);
   logic prev_q;
   logic hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         prev_q <= sig_in;
         if (sw_set || (edge_mode && sig_in && !prev_q))
            hold_q <= 1'b1;
         else if (sw_clr)
            hold_q <= 1'b0;
      end
   end

   // level lines follow the wire; the latch only carries software/edge state
   assign pend_o = hold_q | (~edge_mode & sig_in);
endmodule

// File: rtl/intd_select.sv
module intd_select #(
   parameter int N    = 64,
   parameter int ID_W = $clog2(N)
) (
   input  logic [N-1:0]      cand,
   input  logic [N-1:0][7:0] pr,
   output logic              found,
   output logic [ID_W-1:0]   id,
   output logic [7:0]        best
);
   always_comb begin
      found = 1'b0;
      id    = '0;
      best  = 8'hFF;
      // strict compare keeps the lower index on a tie
      for (int i = 0; i < N; i++) begin
         if (cand[i] && (!found || pr[i] < best)) begin
            found = 1'b1;
            id    = ID_W'(i);
            best  = pr[i];
         end
      end
   end
endmodule

// File: rtl/intd_distributor.sv
module intd_distributor
   import intd_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  reg_wr,
   input  logic [CPU_SEL_W-1:0]                  reg_cpu,
   input  logic [REG_AW-1:0]                     reg_addr,
   input  logic [31:0]                           reg_wdata,
   output logic [31:0]                           reg_rdata,
   input  logic [NUM_CPUS*PPI_LINES-1:0]         ppi_in,
   input  logic [NUM_LINES-BANK_LINES-1:0]       spi_in,
   output logic [NUM_CPUS-1:0]                   irq_valid,
   output logic [NUM_CPUS*$clog2(NUM_LINES)-1:0] irq_id,
   output logic [NUM_CPUS*PRIO_W-1:0]            irq_prio
);
   localparam int ID_W     = $clog2(NUM_LINES);
   localparam int SPI_N    = NUM_LINES - BANK_LINES;
   localparam int EN_WORDS = NUM_LINES / 32;
   localparam int PR_WORDS = NUM_LINES / 4;
   localparam int CF_WORDS = NUM_LINES / 16;
   localparam logic [4:0] TYPE_N = 5'(NUM_LINES / 32 - 1);

   // elaboration-time parameter checks
   if (NUM_LINES % 32 != 0 || NUM_LINES < 64 || NUM_LINES > 512) begin : g_bad_lines
      $fatal(1, "NUM_LINES must be a multiple of 32 in 64..512");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > MAX_CPUS) begin : g_bad_cpus
      $fatal(1, "NUM_CPUS must be 1..8");
   end

   // ---------------- state ----------------
   logic                                ctrl_en;
   logic [NUM_CPUS-1:0][BANK_LINES-1:0] ena_bank;
   logic [SPI_N-1:0]                    ena_spi;
   logic [NUM_LINES-1:0][PRIO_W-1:0]    prio;
   logic [SPI_N-1:0][NUM_CPUS-1:0]      tgt;
   logic [NUM_LINES-1:0]                edge_cfg;

   logic [NUM_CPUS-1:0][BANK_LINES-1:0] pnd_bank;
   logic [SPI_N-1:0]                    pnd_spi;
   logic [NUM_CPUS-1:0][BANK_LINES-1:0] bset, bclr;
   logic [SPI_N-1:0]                    sset, sclr;

   // ---------------- decode ----------------
   logic       hit_ctrl, hit_type, hit_enset, hit_enclr, hit_pset, hit_pclr;
   logic       hit_prio, hit_tgt, hit_cfg, hit_swi;
   logic [3:0] w16;
   logic [7:0] w256;

   assign w16  = reg_addr[3:0];
   assign w256 = reg_addr[7:0];

   always_comb begin
      hit_ctrl  = (reg_addr == A_CTRL);
      hit_type  = (reg_addr == A_TYPE);
      hit_swi   = (reg_addr == A_SWI);
      hit_enset = (reg_addr[9:4] == A_ENSET[9:4])  && (int'(w16) < EN_WORDS);
      hit_enclr = (reg_addr[9:4] == A_ENCLR[9:4])  && (int'(w16) < EN_WORDS);
      hit_pset  = (reg_addr[9:4] == A_PNDSET[9:4]) && (int'(w16) < EN_WORDS);
      hit_pclr  = (reg_addr[9:4] == A_PNDCLR[9:4]) && (int'(w16) < EN_WORDS);
      hit_prio  = (reg_addr[9:8] == A_PRIO[9:8]) && (int'(w256) < PR_WORDS);
      hit_tgt   = (reg_addr[9:8] == A_TGT[9:8])  && (int'(w256) < PR_WORDS);
      hit_cfg   = (reg_addr[9:8] == A_CFG[9:8])  && (reg_addr[7:6] != 2'b11)
                  && (int'(w256) < CF_WORDS);
   end

   // ---------------- software pending requests ----------------
   always_comb begin
      for (int c = 0; c < NUM_CPUS; c++) begin
         for (int b = 0; b < BANK_LINES; b++) begin
            bset[c][b] = reg_wr && hit_pset && (w16 == 4'd0)
                         && (reg_cpu == CPU_SEL_W'(c)) && reg_wdata[b];
            bclr[c][b] = reg_wr && hit_pclr && (w16 == 4'd0)
                         && (reg_cpu == CPU_SEL_W'(c)) && reg_wdata[b];
         end
         for (int b = 0; b < SGI_LINES; b++) begin
            if (reg_wr && hit_swi && reg_wdata[16+c] && (reg_wdata[3:0] == 4'(b)))
               bset[c][b] = 1'b1;
         end
      end
      for (int j = 0; j < SPI_N; j++) begin
         sset[j] = reg_wr && hit_pset && (int'(w16) == (j + 32) / 32)
                   && reg_wdata[(j + 32) % 32];
         sclr[j] = reg_wr && hit_pclr && (int'(w16) == (j + 32) / 32)
                   && reg_wdata[(j + 32) % 32];
      end
   end

   // ---------------- pending cells ----------------
   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu_bank
      for (genvar b = 0; b < BANK_LINES; b++) begin : g_line
         logic src;
         if (b >= SGI_LINES) begin : g_ppi
            assign src = ppi_in[c*PPI_LINES + b - SGI_LINES];
         end else begin : g_sgi
            assign src = 1'b0;
         end
         intd_pend_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .sig_in    (src),
            .edge_mode (edge_cfg[b]),
            .sw_set    (bset[c][b]),
            .sw_clr    (bclr[c][b]),
            .pend_o    (pnd_bank[c][b])
         );
      end
   end

   for (genvar j = 0; j < SPI_N; j++) begin : g_spi
      intd_pend_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .sig_in    (spi_in[j]),
         .edge_mode (edge_cfg[BANK_LINES + j]),
         .sw_set    (sset[j]),
         .sw_clr    (sclr[j]),
         .pend_o    (pnd_spi[j])
      );
   end

   // ---------------- configuration registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         ena_bank <= '0;
         ena_spi  <= '0;
         prio     <= '0;
         tgt      <= '0;
         edge_cfg <= {{(NUM_LINES-SGI_LINES){1'b0}}, {SGI_LINES{1'b1}}};
      end else if (reg_wr) begin
         if (hit_ctrl)
            ctrl_en <= reg_wdata[0];
         if (hit_enset || hit_enclr) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
               if (w16 == 4'd0 && reg_cpu == CPU_SEL_W'(c))
                  ena_bank[c] <= hit_enset ? (ena_bank[c] | reg_wdata)
                                           : (ena_bank[c] & ~reg_wdata);
            end
            for (int j = 0; j < SPI_N; j++) begin
               if (int'(w16) == (j + 32) / 32 && reg_wdata[(j + 32) % 32])
                  ena_spi[j] <= hit_enset;
            end
         end
         if (hit_prio) begin
            for (int i = 0; i < NUM_LINES; i++) begin
               if (int'(w256) == i / 4)
                  prio[i] <= reg_wdata[8*(i%4) +: 8];
            end
         end
         if (hit_tgt) begin
            for (int j = 0; j < SPI_N; j++) begin
               if (int'(w256) == (j + 32) / 4)
                  tgt[j] <= reg_wdata[8*((j + 32) % 4) +: NUM_CPUS];
            end
         end
         if (hit_cfg) begin
            for (int i = SGI_LINES; i < NUM_LINES; i++) begin
               if (int'(w256) == i / 16)
                  edge_cfg[i] <= reg_wdata[2*(i%16) + 1];
            end
         end
      end
   end

   // ---------------- per-processor views ----------------
   logic [NUM_CPUS-1:0][NUM_LINES-1:0] ena_view, pnd_view, route_view, cand;
   logic [NUM_LINES-1:0]               rd_ena, rd_pnd;
   logic [7:0]                         own_bit;

   always_comb begin
      for (int c = 0; c < NUM_CPUS; c++) begin
         ena_view[c] = {ena_spi, ena_bank[c]};
         pnd_view[c] = {pnd_spi, pnd_bank[c]};
         for (int i = 0; i < BANK_LINES; i++)
            route_view[c][i] = 1'b1;
         for (int j = 0; j < SPI_N; j++)
            route_view[c][BANK_LINES + j] = tgt[j][c];
         cand[c] = ena_view[c] & pnd_view[c] & route_view[c];
      end
      rd_ena = '0;
      rd_pnd = '0;
      for (int c = 0; c < NUM_CPUS; c++) begin
         if (reg_cpu == CPU_SEL_W'(c)) begin
            rd_ena = ena_view[c];
            rd_pnd = pnd_view[c];
         end
      end
      own_bit = (8'd1 << reg_cpu) & 8'((1 << NUM_CPUS) - 1);
   end

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (hit_ctrl)
         reg_rdata[0] = ctrl_en;
      if (hit_type)
         reg_rdata[4:0] = TYPE_N;
      for (int w = 0; w < EN_WORDS; w++) begin
         if (int'(w16) == w) begin
            if (hit_enset || hit_enclr) reg_rdata = rd_ena[w*32 +: 32];
            if (hit_pset  || hit_pclr)  reg_rdata = rd_pnd[w*32 +: 32];
         end
      end
      if (hit_prio) begin
         for (int w = 0; w < PR_WORDS; w++) begin
            if (int'(w256) == w)
               for (int k = 0; k < 4; k++)
                  reg_rdata[8*k +: 8] = prio[4*w + k];
         end
      end
      if (hit_tgt) begin
         for (int w = 0; w < BANK_LINES / 4; w++) begin
            if (int'(w256) == w)
               reg_rdata = {4{own_bit}};
         end
         for (int w = BANK_LINES / 4; w < PR_WORDS; w++) begin
            if (int'(w256) == w)
               for (int k = 0; k < 4; k++)
                  reg_rdata[8*k +: NUM_CPUS] = tgt[4*w + k - BANK_LINES];
         end
      end
      if (hit_cfg) begin
         for (int w = 0; w < CF_WORDS; w++) begin
            if (int'(w256) == w)
               for (int k = 0; k < 16; k++)
                  reg_rdata[2*k + 1] = edge_cfg[16*w + k];
         end
      end
   end

   // ---------------- arbitration and output registers ----------------
   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_arb
      logic            found;
      logic [ID_W-1:0] win_id;
      logic [7:0]      win_pr;

      intd_select #(.N(NUM_LINES), .ID_W(ID_W)) u_sel (
         .cand  (cand[c]),
         .pr    (prio),
         .found (found),
         .id    (win_id),
         .best  (win_pr)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_valid[c]                 <= 1'b0;
            irq_id[c*ID_W +: ID_W]       <= '0;
            irq_prio[c*PRIO_W +: PRIO_W] <= '0;
         end else begin
            irq_valid[c]                 <= ctrl_en && found;
            irq_id[c*ID_W +: ID_W]       <= win_id;
            irq_prio[c*PRIO_W +: PRIO_W] <= win_pr;
         end
      end
   end
endmodule

// File: rtl/intd_checker.sv
module intd_checker
   import intd_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic [REG_AW-1:0]   reg_addr,
   input logic [31:0]         reg_wdata,
   input logic [31:0]         reg_rdata,
   input logic [NUM_CPUS-1:0] irq_valid,
   input logic                ctrl_en,
   input logic [31:0]         ena_lo
);
   localparam logic [31:0] TYPE_WORD = 32'(NUM_LINES / 32 - 1);
   localparam logic [REG_AW-1:0] A_ENSET1 = A_ENSET + 10'd1;
   localparam logic [REG_AW-1:0] A_ENCLR1 = A_ENCLR + 10'd1;

   AST_FWD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CTRL && !reg_wdata[0]) |=> ##1 (irq_valid == '0)); // R2

   AST_FWD_NEEDS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid != '0) |-> $past(ctrl_en)); // R2

   AST_TYPE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_TYPE) |-> (reg_rdata == TYPE_WORD)); // R11

   AST_SWI_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_SWI) |-> (reg_rdata == 32'h0)); // R11

   AST_SGI_CFG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_CFG) |-> (reg_rdata == 32'hAAAA_AAAA)); // R5

   AST_ENSET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_ENSET1) |=> ((ena_lo & $past(reg_wdata)) == $past(reg_wdata))); // R3

   AST_ENCLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_ENCLR1) |=> ((ena_lo & $past(reg_wdata)) == 32'h0)); // R3

   AST_ENA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(ena_lo)); // R3
endmodule

bind intd_distributor intd_checker #(
   .NUM_LINES (NUM_LINES),
   .NUM_CPUS  (NUM_CPUS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_valid (irq_valid),
   .ctrl_en   (ctrl_en),
   .ena_lo    (ena_spi[31:0])
);

// File: tb/sim_intd_distributor.sv
module sim_intd_distributor;
   import intd_pkg::*;

   localparam int NL   = 64;
   localparam int NC   = 4;
   localparam int ID_W = $clog2(NL);

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  reg_wr = 1'b0;
   logic [CPU_SEL_W-1:0]  reg_cpu = '0;
   logic [REG_AW-1:0]     reg_addr = '0;
   logic [31:0]           reg_wdata = '0;
   logic [31:0]           reg_rdata;
   logic [NC*16-1:0]      ppi_in = '0;
   logic [NL-33:0]        spi_in = '0;
   logic [NC-1:0]         irq_valid;
   logic [NC*ID_W-1:0]    irq_id;
   logic [NC*8-1:0]       irq_prio;

   always #10 clk = ~clk; // 50 MHz

   intd_distributor #(.NUM_LINES(NL), .NUM_CPUS(NC)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_cpu(reg_cpu),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ppi_in(ppi_in), .spi_in(spi_in), .irq_valid(irq_valid),
      .irq_id(irq_id), .irq_prio(irq_prio));

   typedef struct {
      bit          is_irq;
      int          cpu;
      logic [31:0] exp;
      bit          vld;
      int          id;
      int          pr;
      string       tag;
   } item_t;

   item_t sb[$];
   int pushed = 0, popped = 0, checks = 0, fails = 0;
   bit finished = 0;

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         wait (pushed > popped);
         #2;
         begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (!it.is_irq) begin
               if (reg_rdata !== it.exp) begin
                  fails++;
                  $display("FAIL %s: read actual %h expected %h", it.tag, reg_rdata, it.exp);
               end
            end else begin
               logic       av;
               logic [5:0] aid;
               logic [7:0] apr;
               av  = irq_valid[it.cpu];
               aid = irq_id[it.cpu*ID_W +: ID_W];
               apr = irq_prio[it.cpu*8 +: 8];
               if (av !== it.vld || (it.vld && (int'(aid) != it.id || int'(apr) != it.pr))) begin
                  fails++;
                  $display("FAIL %s: cpu%0d actual v=%0d id=%0d pr=%h expected v=%0d id=%0d pr=%h",
                           it.tag, it.cpu, av, aid, apr, it.vld, it.id, it.pr[7:0]);
               end
            end
            popped++;
         end
      end
   end

   task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d, input int cpu);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_cpu = CPU_SEL_W'(cpu);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic exp_rd(input logic [REG_AW-1:0] a, input int cpu,
                         input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_addr = a; reg_cpu = CPU_SEL_W'(cpu);
      it.is_irq = 0; it.cpu = cpu; it.exp = e; it.vld = 0; it.id = 0; it.pr = 0; it.tag = tag;
      sb.push_back(it);
      pushed++;
      wait (popped == pushed);
   endtask

   task automatic exp_irq(input int cpu, input bit v, input int id, input int pr,
                          input string tag);
      item_t it;
      it.is_irq = 1; it.cpu = cpu; it.exp = '0; it.vld = v; it.id = id; it.pr = pr; it.tag = tag;
      sb.push_back(it);
      pushed++;
      wait (popped == pushed);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      exp_rd(A_CTRL, 0, 32'h0, "R1 ctrl");
      exp_rd(A_ENSET + 10'd1, 0, 32'h0, "R1 shared enables");
      exp_rd(A_PNDSET, 0, 32'h0, "R1 private pending");
      exp_rd(A_PRIO + 10'd8, 0, 32'h0, "R1 priority");
      exp_rd(A_CFG + 10'd2, 0, 32'h0, "R1 level config");
      for (int c = 0; c < NC; c++) exp_irq(c, 0, 0, 0, "R1 no irq");

      // R11 identification and switch readback
      exp_rd(A_TYPE, 0, 32'h1, "R11 type");
      exp_rd(A_SWI, 0, 32'h0, "R11 swi reads zero");

      // R5 configuration
      exp_rd(A_CFG, 0, 32'hAAAA_AAAA, "R5 fixed sgi cfg");
      wr(A_CFG, 32'hFFFF_FFFF, 0);
      exp_rd(A_CFG, 0, 32'hAAAA_AAAA, "R5 sgi cfg write ignored");
      wr(A_CFG + 10'd2, 32'h3, 0);
      exp_rd(A_CFG + 10'd2, 0, 32'h2, "R5 upper bit only");

      // R3 enable views
      wr(A_ENSET + 10'd1, 32'hF0, 0);
      exp_rd(A_ENSET + 10'd1, 0, 32'hF0, "R3 set view");
      exp_rd(A_ENCLR + 10'd1, 0, 32'hF0, "R3 clear view reads enables");
      wr(A_ENCLR + 10'd1, 32'h30, 0);
      exp_rd(A_ENSET + 10'd1, 0, 32'hC0, "R3 clear bits");
      wr(A_ENSET + 10'd1, 32'h0, 0);
      exp_rd(A_ENSET + 10'd1, 0, 32'hC0, "R3 zero bits no effect");

      // R8 private enables
      wr(A_ENSET, 32'h1, 1);
      exp_rd(A_ENSET, 0, 32'h0, "R8 cpu0 copy untouched");
      exp_rd(A_ENSET, 1, 32'h1, "R8 cpu1 copy");

      // R7 priority and target layout
      wr(A_PRIO + 10'd8, 32'h4030_2010, 0);
      exp_rd(A_PRIO + 10'd8, 0, 32'h4030_2010, "R7 priority bytes");
      exp_rd(A_TGT, 2, 32'h0404_0404, "R7 private target own bit");
      wr(A_TGT, 32'hFFFF_FFFF, 2);
      exp_rd(A_TGT, 0, 32'h0101_0101, "R7 private target write ignored");

      // R10 selection with ties and reprioritisation
      wr(A_CTRL, 32'h1, 0);
      exp_rd(A_CTRL, 0, 32'h1, "R11 ctrl readback");
      wr(A_TGT + 10'd9, 32'h0101_0101, 0);
      wr(A_PRIO + 10'd9, 32'h5050_6070, 0);
      wr(A_PNDSET + 10'd1, 32'hC0, 0);
      idle(2);
      exp_irq(0, 1, 38, 8'h50, "R10 tie lowest line");
      exp_irq(1, 0, 0, 0, "R10 unrouted cpu idle");
      wr(A_PRIO + 10'd9, 32'h1050_6070, 0);
      idle(2);
      exp_irq(0, 1, 39, 8'h10, "R10 lower value wins");
      wr(A_PNDCLR + 10'd1, 32'h80, 0);
      idle(2);
      exp_irq(0, 1, 38, 8'h50, "R4 clear pending returns to 38");

      // R2 forwarding switch
      wr(A_CTRL, 32'h0, 0);
      idle(1);
      exp_irq(0, 0, 0, 0, "R2 forwarding off");
      wr(A_CTRL, 32'h1, 0);
      idle(2);
      exp_irq(0, 1, 38, 8'h50, "R2 forwarding back");

      // R6 level line 40 and edge line 41
      wr(A_ENSET + 10'd1, 32'h300, 0);
      wr(A_TGT + 10'd10, 32'h0000_0202, 0);
      wr(A_PRIO + 10'd10, 32'h0000_0605, 0);
      wr(A_CFG + 10'd2, 32'h0008_0002, 0);
      @(negedge clk); spi_in[8] = 1'b1;
      idle(2);
      exp_irq(1, 1, 40, 8'h05, "R6 level pending");
      exp_rd(A_PNDSET + 10'd1, 0, 32'h140, "R4 pending read");
      wr(A_PNDCLR + 10'd1, 32'h100, 0);
      exp_rd(A_PNDSET + 10'd1, 0, 32'h140, "R6 level clear no effect");
      @(negedge clk); spi_in[8] = 1'b0;
      idle(2);
      exp_irq(1, 0, 0, 0, "R6 level drops");
      @(negedge clk); spi_in[9] = 1'b1;
      @(negedge clk); spi_in[9] = 1'b0;
      idle(2);
      exp_irq(1, 1, 41, 8'h06, "R6 edge latched");
      exp_rd(A_PNDSET + 10'd1, 0, 32'h240, "R6 edge held");
      wr(A_PNDCLR + 10'd1, 32'h200, 0);
      idle(2);
      exp_irq(1, 0, 0, 0, "R6 edge cleared");

      // R9 software interrupt to cpus 2 and 3
      wr(A_ENSET, 32'h20, 2);
      wr(A_ENSET, 32'h0010_0020, 3);
      wr(A_SWI, 32'h000C_0005, 0);
      idle(2);
      exp_irq(2, 1, 5, 0, "R9 cpu2 raised");
      exp_irq(3, 1, 5, 0, "R9 cpu3 raised");
      exp_irq(0, 1, 38, 8'h50, "R9 cpu0 unaffected");
      exp_rd(A_PNDSET, 0, 32'h0, "R9 cpu0 copy clear");
      exp_rd(A_PNDSET, 3, 32'h20, "R9 cpu3 copy set");

      // R8 private input for line 20 of cpu3
      @(negedge clk); ppi_in[3*16 + 4] = 1'b1;
      idle(2);
      exp_rd(A_PNDSET, 3, 32'h0010_0020, "R8 cpu3 private input");
      exp_rd(A_PNDSET, 2, 32'h20, "R8 cpu2 not affected");
      exp_irq(3, 1, 5, 0, "R10 tie keeps line 5");
      wr(A_PNDCLR, 32'h20, 3);
      idle(2);
      exp_irq(3, 1, 20, 0, "R8 line 20 presented");
      exp_irq(2, 1, 5, 0, "R8 cpu2 keeps own line");

      idle(2);
      summary();
   end
endmodule